// File: doc/BRIEF.md
# Buffered SPI Master Transfer Engine

This block is a memory-mapped SPI master that runs one whole transfer from a shared byte buffer. The host first writes a 16-bit operation header into the first two buffer bytes and, when it sends data, the transmit payload after them. It then writes the command register with a slave number, a profile index and the start bit. The engine reads the header, limits the byte count to what the buffer can hold, drives the chosen chip select, and shifts data out on MOSI while it samples MISO. It writes each received byte back into the buffer from offset 0. A status bit stays high for the whole transfer.

The SCLK rate comes from outside: each cycle with `sclk_en_i` high is one half period of SCLK. A control register holds the idle level of every chip-select line, the SCLK idle polarity and a clock-gate enable. When the gate is off, the engine ignores the half-period ticks.

Host addressing is in bytes. Address bit 9 selects the buffer, and the buffer offset is address bits 8:0. The buffer uses data byte lane 7:0, and buffer reads return that byte with zeros above it. With bit 9 clear, address bits 3:2 select a register: 0 is control, 1 is status and 2 is command.

Top module: `spi_pp_engine`

## Requirements
- R1: After reset, status bit 1 reads 0 and control reads 0x000000FF. All chip-select outputs are high, `sclk_o` and `mosi_o` are low, and `prof_o` is 0.
- R2: A command write with bit 0 set while idle starts a transfer. The slave number comes from bits 14:12 and the profile from bits 10:8, and the profile appears on `prof_o`. Status bit 1 reads 1 from the clock after the write until the transfer ends.
- R3: Buffer byte 0 holds header bits 15:8 and byte 1 holds bits 7:0. The byte count is in bits 9:0 and the opcode in bits 14:13: 1 is read+write, 2 is write-only, 3 is read-only, and 0 acts as write-only. The dual flag in bit 11 does not change the transfer.
- R4: Bytes go out most-significant bit first. MOSI is stable on the SCLK edge that leaves the idle level, which is also the edge where MISO is sampled. MOSI changes on the edge that returns to idle. Transmit byte k comes from buffer offset 2+k. In read-only mode MOSI stays low.
- R5: In read+write and read-only modes, received byte k is stored at buffer offset k. A write-only transfer leaves the whole buffer unchanged.
- R6: The number of bytes moved is the header count, capped at 512 for read-only and at 510 for modes that transmit. A count of 0 finishes with no chip-select activity and no SCLK edges.
- R7: A chip-select output equals its control bit (7:0) at all times, except the selected line, which is inverted during the shift phase. The line returns to idle in the same cycle that the status busy bit clears.
- R8: While busy, command writes are ignored (no restart, and `prof_o` is unchanged), and host writes to the buffer are ignored.
- R9: While control bit 16 (clock gate) is 0, ticks are ignored: SCLK stays at idle and the transfer does not advance.
- R10: Control bit 17 sets the idle level of `sclk_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Host write strobe |
| addr_i | input | 10 | Host byte address |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Host read data (combinational) |
| sclk_en_i | input | 1 | SCLK half-period tick |
| miso_i | input | 1 | Serial data from the slave |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data to the slave |
| cs_o | output | 8 | Chip-select lines |
| prof_o | output | 3 | Profile index of the accepted command |

## Verification
The bench uses the default parameters: a 512-byte buffer and eight chip-select lines. The default buffer size makes both length caps reachable, a 1023-byte read clipped to 512 and a 600-byte read+write clipped to 510. A behavioural slave checks every bit, and the full buffer is read back after each transfer. Eight select lines let random transfers spread over every slave number while the idle-level mask is randomised.

// File: rtl/spi_pp_pkg.sv
package spi_pp_pkg;
  localparam int BYTE_W    = 8;
  localparam int HDR_W     = 16;
  localparam int HDR_BYTES = 2;
  localparam int CNT_W     = 10;
  localparam int OP_LSB    = 13;
  localparam int SEL_W     = 3;

  localparam logic [1:0] OP_RW = 2'd1;
  localparam logic [1:0] OP_WR = 2'd2;
  localparam logic [1:0] OP_RD = 2'd3;

  localparam logic [1:0] RSEL_CTRL = 2'd0;
  localparam logic [1:0] RSEL_STAT = 2'd1;
  localparam logic [1:0] RSEL_CMD  = 2'd2;

  localparam int CTRL_GATE_BIT = 16;
  localparam int CTRL_CPOL_BIT = 17;
  localparam int STAT_BUSY_BIT = 1;
  localparam int CMD_PROF_LSB  = 8;
  localparam int CMD_SLV_LSB   = 12;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT} seq_st_e;
endpackage

// File: rtl/spi_pp_buf.sv
module spi_pp_buf #(
  parameter int DEPTH = 512,
  parameter int AW    = 9,
  parameter int N_RD  = 4,
  parameter int W     = 8
) (
  input  logic                      clk_i,
  input  logic                      we_i,
  input  logic [AW-1:0]             waddr_i,
  input  logic [W-1:0]              wdata_i,
  input  logic [N_RD-1:0][AW-1:0]   raddr_i,
  output logic [N_RD-1:0][W-1:0]    rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar g = 0; g < N_RD; g++) begin : g_rd
    assign rdata_o[g] = mem_q[raddr_i[g]];
  end
endmodule

// File: rtl/spi_pp_shift.sv
module spi_pp_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic         tx_en_i,
  input  logic [W-1:0] byte_i,
  input  logic         miso_i,
  output logic         half_o,
  output logic         mosi_o,
  output logic         byte_done_o,
  output logic [W-1:0] rx_byte_o
);
  localparam int BW = $clog2(W);

  logic [W-1:0]  tx_q, rx_q;
  logic [BW-1:0] bit_q;
  logic          half_q;
  logic          last_bit;

  assign last_bit = (bit_q == BW'(W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      half_q <= 1'b0;
    end else if (load_i) begin
      tx_q   <= byte_i;
      bit_q  <= '0;
      half_q <= 1'b0;
    end else if (run_i && tick_i) begin
      if (!half_q) begin
        half_q <= 1'b1;
        rx_q   <= {rx_q[W-2:0], miso_i};
      end else begin
        half_q <= 1'b0;
        if (last_bit) begin
          bit_q <= '0;
          tx_q  <= byte_i;
        end else begin
          bit_q <= bit_q + BW'(1);
          tx_q  <= {tx_q[W-2:0], 1'b0};
        end
      end
    end else if (!run_i) begin
      half_q <= 1'b0;
    end
  end

  assign half_o      = half_q;
  assign mosi_o      = run_i && tx_en_i && tx_q[W-1];
  assign byte_done_o = run_i && tick_i && half_q && last_bit;
  assign rx_byte_o   = rx_q;

  AST_HALF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i && !load_i) |=> $stable(half_q)); // R9
endmodule

// File: rtl/spi_pp_seq.sv
module spi_pp_seq
  import spi_pp_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SEL_W-1:0] cmd_slave_i,
  input  logic [SEL_W-1:0] cmd_prof_i,
  input  logic [HDR_W-1:0] hdr_i,
  input  logic             byte_done_i,
  output logic             busy_o,
  output logic             load_o,
  output logic             run_o,
  output logic             tx_en_o,
  output logic             rx_en_o,
  output logic [CNT_W-1:0] idx_o,
  output logic [SEL_W-1:0] slave_o,
  output logic [SEL_W-1:0] prof_o
);
  seq_st_e          st_q;
  logic [1:0]       op_q, hdr_op;
  logic [CNT_W-1:0] cnt_q, idx_q, hdr_cnt, lim, eff_cnt;
  logic [SEL_W-1:0] slave_q, prof_q;
  logic             unused_hdr;

  assign hdr_op     = hdr_i[OP_LSB +: 2];
  assign hdr_cnt    = hdr_i[CNT_W-1:0];
  assign lim        = (hdr_op == OP_RD) ? CNT_W'(DEPTH) : CNT_W'(DEPTH - HDR_BYTES);
  assign eff_cnt    = (hdr_cnt > lim) ? lim : hdr_cnt;
  assign unused_hdr = ^{hdr_i[15], hdr_i[12:10]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      op_q    <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      slave_q <= '0;
      prof_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q    <= ST_LOAD;
          slave_q <= cmd_slave_i;
          prof_q  <= cmd_prof_i;
        end
        ST_LOAD: begin
          op_q  <= hdr_op;
          cnt_q <= eff_cnt;
          idx_q <= '0;
          st_q  <= (eff_cnt == '0) ? ST_IDLE : ST_SHIFT;
        end
        ST_SHIFT: if (byte_done_i) begin
          if (idx_q == cnt_q - CNT_W'(1)) st_q <= ST_IDLE;
          else                            idx_q <= idx_q + CNT_W'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q != ST_IDLE);
  assign load_o  = (st_q == ST_LOAD);
  assign run_o   = (st_q == ST_SHIFT);
  assign tx_en_o = (op_q != OP_RD);
  assign rx_en_o = (op_q == OP_RW) || (op_q == OP_RD);
  assign idx_o   = idx_q;
  assign slave_o = slave_q;
  assign prof_o  = prof_q;

  AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> (idx_q < cnt_q)); // R6
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(slave_q) && $stable(prof_q))); // R8
endmodule

// File: rtl/spi_pp_engine.sv
module spi_pp_engine
  import spi_pp_pkg::*;
#(
  parameter int BUF_BYTES = 512,
  parameter int N_CS      = 8,
  parameter int ADDR_W    = $clog2(BUF_BYTES) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              sclk_en_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic [N_CS-1:0]   cs_o,
  output logic [SEL_W-1:0]  prof_o
);
  localparam int AW   = $clog2(BUF_BYTES);
  localparam int N_RD = 4;

  logic              buf_sel, start, host_bwe, eng_we, busy, load, run;
  logic              tx_en, rx_en, half, byte_done, tick;
  logic [1:0]        rsel;
  logic [AW-1:0]     boff;
  logic [CNT_W-1:0]  idx;
  logic [SEL_W-1:0]  slave;
  logic [BYTE_W-1:0] rx_byte;
  logic [N_RD-1:0][AW-1:0]     rd_addr;
  logic [N_RD-1:0][BYTE_W-1:0] rd_data;
  logic [N_CS-1:0]   cs_idle_q;
  logic              gate_q, cpol_q;
  logic              unused_wdata;

  assign buf_sel  = addr_i[ADDR_W-1];
  assign boff     = addr_i[AW-1:0];
  assign rsel     = addr_i[3:2];
  assign start    = we_i && !buf_sel && (rsel == RSEL_CMD) && wdata_i[0];
  assign host_bwe = we_i && buf_sel && !busy;
  assign eng_we   = byte_done && rx_en;
  assign tick     = sclk_en_i && gate_q;
  assign unused_wdata = ^{wdata_i[31:18], wdata_i[15], wdata_i[11]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_idle_q <= '1;
      gate_q    <= 1'b0;
      cpol_q    <= 1'b0;
    end else if (we_i && !buf_sel && (rsel == RSEL_CTRL)) begin
      cs_idle_q <= wdata_i[N_CS-1:0];
      gate_q    <= wdata_i[CTRL_GATE_BIT];
      cpol_q    <= wdata_i[CTRL_CPOL_BIT];
    end
  end

  // port 0 host, 1/2 header, 3 next transmit byte
  assign rd_addr[0] = boff;
  assign rd_addr[1] = AW'(0);
  assign rd_addr[2] = AW'(1);
  assign rd_addr[3] = load ? AW'(HDR_BYTES) : AW'(idx + CNT_W'(HDR_BYTES + 1));

  spi_pp_buf #(.DEPTH(BUF_BYTES), .AW(AW), .N_RD(N_RD), .W(BYTE_W)) u_buf (
    .clk_i   (clk_i),
    .we_i    (host_bwe || eng_we),
    .waddr_i (eng_we ? idx[AW-1:0] : boff),
    .wdata_i (eng_we ? rx_byte : wdata_i[BYTE_W-1:0]),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  spi_pp_seq #(.DEPTH(BUF_BYTES)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .cmd_slave_i (wdata_i[CMD_SLV_LSB +: SEL_W]),
    .cmd_prof_i  (wdata_i[CMD_PROF_LSB +: SEL_W]),
    .hdr_i       ({rd_data[1], rd_data[2]}),
    .byte_done_i (byte_done),
    .busy_o      (busy),
    .load_o      (load),
    .run_o       (run),
    .tx_en_o     (tx_en),
    .rx_en_o     (rx_en),
    .idx_o       (idx),
    .slave_o     (slave),
    .prof_o      (prof_o)
  );

  spi_pp_shift #(.W(BYTE_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .run_i       (run),
    .tick_i      (tick),
    .tx_en_i     (tx_en),
    .byte_i      (rd_data[3]),
    .miso_i      (miso_i),
    .half_o      (half),
    .mosi_o      (mosi_o),
    .byte_done_o (byte_done),
    .rx_byte_o   (rx_byte)
  );

  assign sclk_o = cpol_q ^ half;

  for (genvar g = 0; g < N_CS; g++) begin : g_cs
    assign cs_o[g] = cs_idle_q[g] ^ (run && (slave == SEL_W'(g)));
  end

  always_comb begin
    rdata_o = '0;
    if (buf_sel) begin
      rdata_o[BYTE_W-1:0] = rd_data[0];
    end else begin
      unique case (rsel)
        RSEL_CTRL: begin
          rdata_o[N_CS-1:0]     = cs_idle_q;
          rdata_o[CTRL_GATE_BIT] = gate_q;
          rdata_o[CTRL_CPOL_BIT] = cpol_q;
        end
        RSEL_STAT: rdata_o[STAT_BUSY_BIT] = busy;
        RSEL_CMD: begin
          rdata_o[CMD_PROF_LSB +: SEL_W] = prof_o;
          rdata_o[CMD_SLV_LSB +: SEL_W]  = slave;
        end
        default: rdata_o = '0;
      endcase
    end
  end

  AST_CS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (cs_o == cs_idle_q)); // R7
  AST_SCLK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (sclk_o == cpol_q)); // R10
  AST_NO_BUF_WR_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !eng_we) |=> $stable(rd_data[1])); // R8
endmodule

// File: tb/spi_pp_engine_test.sv
module spi_pp_engine_test;
  localparam int NB = 512;
  localparam int NCS = 8;
  localparam logic [9:0] A_CTRL = 10'h000, A_STAT = 10'h004, A_CMD = 10'h008, A_BUF = 10'h200;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, sclk_en = 1'b0, miso = 1'b0;
  logic [9:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic sclk, mosi;
  logic [NCS-1:0] cs;
  logic [2:0] prof;

  spi_pp_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .sclk_en_i(sclk_en), .miso_i(miso), .sclk_o(sclk),
    .mosi_o(mosi), .cs_o(cs), .prof_o(prof)
  );

  always #2 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  logic [7:0] exp_buf [NB];
  logic [7:0] sl_data [NB];
  logic [7:0] mosi_cap [NB];
  logic [7:0] txp [NB];
  logic [2:0] cur_sel = '0;
  logic [NCS-1:0] cur_idle = '1;
  logic cur_cpol = 1'b0;
  int tick_mode = 0;
  int lead_total = 0, act_cycles = 0, cs_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) sclk_en <= (tick_mode != 0) ? (($urandom % 4) != 0) : 1'b1;

  // behavioural slave, sampled away from the clock edge
  int rx_bits = 0, tx_bits = 0;
  logic prev_act = 1'b0, prev_sclk = 1'b0;
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      logic act;
      act = (cs[cur_sel] != cur_idle[cur_sel]);
      if (cs !== cur_idle && cs !== (cur_idle ^ (NCS'(1) << cur_sel))) cs_bad++;
      if (act) act_cycles++;
      if (act && !prev_act) begin
        rx_bits = 0;
        miso = sl_data[0][7];
        tx_bits = 1;
      end else if (act && prev_sclk == cur_cpol && sclk != cur_cpol) begin
        mosi_cap[(rx_bits / 8) % NB][7 - (rx_bits % 8)] = mosi;
        rx_bits++;
        lead_total++;
      end else if (act && prev_sclk != cur_cpol && sclk == cur_cpol) begin
        miso = sl_data[(tx_bits / 8) % NB][7 - (tx_bits % 8)];
        tx_bits++;
      end
      prev_act = act;
      prev_sclk = sclk;
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic wr_byte(input int off, input logic [7:0] v);
    wr(A_BUF | 10'(off), {24'd0, v});
    exp_buf[off] = v;
  endtask

  task automatic set_ctrl(input logic [7:0] idle, input logic gate, input logic pol);
    @(negedge clk);
    cur_idle = idle; cur_cpol = pol;
    we = 1'b1; addr = A_CTRL; wdata = {14'd0, pol, gate, 8'd0, idle};
    @(negedge clk); we = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int c = 0; c < 20000; c++) begin
      rd(A_STAT, d);
      if (d[1] == 1'b0) return;
    end
    chk(1'b0, "R2", "busy never cleared", 32'd1, 32'd0);
  endtask

  task automatic xfer(input int op, input int cnt, input int sel, input int pr,
                      input bit dual, input bit poke, input bit hold);
    int n, l0, a0, b0, bad;
    logic [15:0] hdr;
    logic [31:0] d;
    bit txm, rxm;
    n   = (op == 3) ? ((cnt > 512) ? 512 : cnt) : ((cnt > 510) ? 510 : cnt);
    txm = (op != 3);
    rxm = (op == 1) || (op == 3);
    hdr = {1'b0, 2'(op), 1'b0, dual, 1'b0, 10'(cnt)};
    wr_byte(0, hdr[15:8]);
    wr_byte(1, hdr[7:0]);
    if (txm) for (int k = 0; k < n; k++) wr_byte(2 + k, 8'($urandom));
    for (int k = 0; k < NB; k++) begin
      sl_data[k] = 8'($urandom);
      mosi_cap[k] = 8'h00;
      txp[k] = (k + 2 < NB) ? exp_buf[k + 2] : 8'h00;
    end
    cur_sel = 3'(sel);
    l0 = lead_total; a0 = act_cycles; b0 = cs_bad;
    wr(A_CMD, 32'((sel << 12) | (pr << 8) | 1));
    addr = A_STAT; #1;
    chk(rdata[1] == 1'b1, "R2", "busy after start", rdata, 32'h2);
    chk(prof == 3'(pr), "R2", "profile output", 32'(prof), 32'(pr));
    if (poke) begin
      wr(A_CMD, 32'((6 << 12) | (2 << 8) | 1));
      wr(A_BUF | 10'd400, 32'h5A);
    end
    if (hold) begin
      repeat (40) @(negedge clk);
      chk(lead_total == l0, "R9", "edges while gated", 32'(lead_total - l0), 32'd0);
      chk(sclk == cur_cpol, "R9", "sclk idle while gated", 32'(sclk), 32'(cur_cpol));
      rd(A_STAT, d);
      chk(d[1] == 1'b1, "R9", "still busy while gated", d, 32'h2);
      set_ctrl(cur_idle, 1'b1, cur_cpol);
    end
    wait_idle();
    chk(cs == cur_idle, "R7", "cs released with busy", 32'(cs), 32'(cur_idle));
    chk(lead_total - l0 == 8 * n, "R6", "bit count", 32'(lead_total - l0), 32'(8 * n));
    if (n == 0) chk(act_cycles == a0, "R6", "no cs for zero count", 32'(act_cycles - a0), 32'd0);
    chk(cs_bad == b0, "R7", "cs pattern", 32'(cs_bad - b0), 32'd0);
    bad = 0;
    for (int k = 0; k < n; k++)
      if (mosi_cap[k] !== (txm ? txp[k] : 8'h00)) begin
        if (bad == 0) chk(1'b0, "R4", "mosi byte", 32'(mosi_cap[k]), 32'(txm ? txp[k] : 8'h00));
        bad++;
      end
    if (bad == 0) chk(1'b1, "R4", "mosi stream", 0, 0);
    if (rxm) for (int k = 0; k < n; k++) exp_buf[k] = sl_data[k];
    bad = 0;
    for (int k = 0; k < NB; k++) begin
      rd(A_BUF | 10'(k), d);
      if (d !== {24'd0, exp_buf[k]}) begin
        if (bad == 0) chk(1'b0, "R5", "buffer byte", d, 32'(exp_buf[k]));
        bad++;
      end
    end
    if (bad == 0) chk(1'b1, "R5", "buffer contents", 0, 0);
    if (poke) begin
      chk(prof == 3'(pr), "R8", "profile after ignored start", 32'(prof), 32'(pr));
      rd(A_BUF | 10'd400, d);
      chk(d[7:0] == exp_buf[400], "R8", "buffer write while busy", d, 32'(exp_buf[400]));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd7717));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(A_STAT, d);  chk(d == 32'd0, "R1", "status", d, 32'd0);
    rd(A_CTRL, d);  chk(d == 32'hFF, "R1", "control", d, 32'hFF);
    chk(cs == 8'hFF, "R1", "cs", 32'(cs), 32'hFF);
    chk(sclk == 1'b0 && mosi == 1'b0, "R1", "sclk/mosi", {sclk, mosi}, 0);
    chk(prof == 3'd0, "R1", "profile", 32'(prof), 0);
    for (int k = 0; k < NB; k++) wr_byte(k, 8'($urandom));
    set_ctrl(8'b1011_0111, 1'b1, 1'b0);
    @(negedge clk);
    chk(cs == 8'b1011_0111, "R7", "idle levels", 32'(cs), 32'hB7);
    xfer(1, 5, 3, 5, 0, 0, 0);
    tick_mode = 1;
    xfer(2, 17, 0, 2, 0, 0, 0);
    set_ctrl(8'b1011_0111, 1'b1, 1'b1);
    @(negedge clk);
    chk(sclk == 1'b1, "R10", "sclk idle high", 32'(sclk), 32'd1);
    xfer(3, 9, 6, 7, 0, 0, 0);
    xfer(0, 4, 1, 1, 0, 0, 0);   // R3 opcode 0 as write
    xfer(3, 6, 2, 0, 1, 0, 0);   // R3 dual flag ignored
    xfer(1, 0, 4, 3, 0, 0, 0);   // R6 zero count
    tick_mode = 0;
    xfer(3, 1023, 5, 1, 0, 0, 0); // R6 read cap
    xfer(1, 600, 7, 4, 0, 0, 0);  // R6 transmit cap
    tick_mode = 1;
    xfer(2, 40, 2, 5, 0, 1, 0);   // R8
    set_ctrl(8'b1011_0111, 1'b0, 1'b0);
    xfer(3, 2, 3, 6, 0, 0, 1);    // R9
    for (int i = 0; i < 6; i++) begin
      set_ctrl(8'($urandom), 1'b1, 1'($urandom));
      xfer(1 + int'($urandom % 3), 1 + int'($urandom % 48), int'($urandom % 8),
           int'($urandom % 8), 1'($urandom), 0, 0);
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule